// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block keeps the interrupt state of one processor across 256 vectors. Three 256-bit sets are kept: vectors waiting for service (the request set), vectors the core has taken but not yet retired (the service set), and the trigger kind each vector last arrived with (the trigger set). A larger vector number always has the higher priority. Delivered vectors enter the request set. The block raises a request line to the core when pending work outranks what is already in service. The core takes the winner through a same-cycle acknowledge and retires it with an end-of-interrupt strobe.

A task-priority register set by software is combined with the class (upper nibble) of the top in-service vector to give the current processor priority. A software-enable input gates acknowledges. Any 32-bit word of the three sets can be read combinationally.

The delivery port is a valid/ready stream whose ready is held high. A beat is taken on every cycle that `dlv_valid` is high, so a source never stalls. The acknowledge port is a request/response pair: `ack_found` and `ack_vector` answer `ack_req` in the same cycle. There is no back-pressure in either direction.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all three sets are zero, the task priority and current priority are 0x00, and `core_irq` is low.
- R2: A delivery beat (`dlv_valid` high, `dlv_ready` always high) sets the request bit of `dlv_vector`, which shows in the read-out from the next cycle on.
- R3: A delivery with `dlv_level`=1 sets the vector's trigger bit, and one with `dlv_level`=0 clears it.
- R4: When `ack_req` is high, `sw_enable` is high and some request is pending, `ack_found` is 1 and `ack_vector` is the highest pending vector number in that same cycle. From the next cycle, that vector's request bit is clear and its service bit is set.
- R5: An acknowledge with `sw_enable` low, or with no request pending, gives `ack_found`=0 and leaves all three sets unchanged.
- R6: `eoi_strobe` clears the highest set service bit only, and does nothing when the service set is empty.
- R7: `core_irq` is high exactly when a request is pending and either the service set is empty or the highest pending vector is above the highest in-service vector.
- R8: Let the class be bits 7:4 of the highest in-service vector, or 0 when none is in service. `cur_prio` equals the task priority when its bits 7:4 are at least the class. Otherwise `cur_prio` is the class followed by four zero bits.
- R9: The read-out selects a set with `rd_sel` (0 request, 1 service, 2 trigger, 3 reads zero). Word `rd_word`=w holds vectors 32w to 32w+31, and bit b is vector 32w+b.
- R10: A delivery, an acknowledge and an end-of-interrupt in the same cycle are all applied. The end-of-interrupt acts on the service set as it stood before the edge. If the delivered vector is also the acknowledged one, it stays pending.
- R11: A write with `task_prio_we` loads `task_prio_wdata`, which shows on `task_prio_q` and in `cur_prio` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlv_valid | input | 1 | Delivery beat valid |
| dlv_ready | output | 1 | Delivery ready, held high |
| dlv_vector | input | 8 | Delivered vector number |
| dlv_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| ack_req | input | 1 | Core acknowledge request |
| ack_found | output | 1 | A vector is returned for this acknowledge |
| ack_vector | output | 8 | Returned vector, meaningful when ack_found is 1 |
| eoi_strobe | input | 1 | End-of-interrupt command |
| sw_enable | input | 1 | Software enable for acknowledges |
| task_prio_we | input | 1 | Task-priority write enable |
| task_prio_wdata | input | 8 | Task-priority write data |
| task_prio_q | output | 8 | Task-priority read-back |
| cur_prio | output | 8 | Current processor priority |
| core_irq | output | 1 | Interrupt request line to the core |
| rd_sel | input | 2 | Read-out set select |
| rd_word | input | 3 | Read-out word index |
| rd_data | output | 32 | Read-out word |

## Verification
`ack_found` and `ack_vector` are combinational, so the bench checks them one time unit after it drives `ack_req`, before the clock edge that applies the acknowledge. All state changes from deliveries, acknowledges, end-of-interrupt and task-priority writes take effect at the next rising edge. The bench therefore compares `core_irq`, `cur_prio`, `task_prio_q` and every read-out word at the following falling edge, after it has returned all strobes to zero. A reference model in the bench advances by one step per edge, so each comparison uses the state that is exactly one edge old.

// File: rtl/lipc_pkg.sv
`timescale 1ns/1ps
package lipc_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_SRV  = 2'd1,
    SEL_TRG  = 2'd2,
    SEL_NONE = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/lipc_prio_enc.sv
`timescale 1ns/1ps
// Highest-set-bit finder over a wide vector.
module lipc_prio_enc #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  bits,
  output logic          any,
  output logic [IW-1:0] top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        any = 1'b1;
        top = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lipc_vec_bank.sv
`timescale 1ns/1ps
// Bit-addressed state set; a set and a clear on the same bit leave it set.
module lipc_vec_bank #(
  parameter int N  = 256,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      if (clr_en) q[clr_idx] <= 1'b0;
      if (set_en) q[set_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl
  import lipc_pkg::*;
#(
  parameter int NVEC  = 256,
  parameter int CLSW  = 4,
  parameter int IDXW  = $clog2(NVEC),
  parameter int WORDS = NVEC / WORD_W,
  parameter int WSELW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dlv_valid,
  output logic             dlv_ready,
  input  logic [IDXW-1:0]  dlv_vector,
  input  logic             dlv_level,
  input  logic             ack_req,
  output logic             ack_found,
  output logic [IDXW-1:0]  ack_vector,
  input  logic             eoi_strobe,
  input  logic             sw_enable,
  input  logic             task_prio_we,
  input  logic [IDXW-1:0]  task_prio_wdata,
  output logic [IDXW-1:0]  task_prio_q,
  output logic [IDXW-1:0]  cur_prio,
  output logic             core_irq,
  input  logic [1:0]       rd_sel,
  input  logic [WSELW-1:0] rd_word,
  output logic [WORD_W-1:0] rd_data
);
  localparam int LOW_W = IDXW - CLSW;

  logic [NVEC-1:0] irr_q, isr_q, tmr_q;
  logic            irr_any, isr_any;
  logic [IDXW-1:0] irr_top, isr_top;
  logic            eoi_clr;
  logic [CLSW-1:0] isr_cls, tpr_cls;

  assign dlv_ready = 1'b1;

  lipc_prio_enc #(.N(NVEC), .IW(IDXW)) u_enc_req (
    .bits(irr_q), .any(irr_any), .top(irr_top));
  lipc_prio_enc #(.N(NVEC), .IW(IDXW)) u_enc_srv (
    .bits(isr_q), .any(isr_any), .top(isr_top));

  assign ack_found  = ack_req & sw_enable & irr_any;
  assign ack_vector = irr_top;
  assign eoi_clr    = eoi_strobe & isr_any;

  // pending set: delivery sets, acknowledge clears (delivery wins)
  lipc_vec_bank #(.N(NVEC), .IW(IDXW)) u_bank_req (
    .clk(clk), .rst_n(rst_n),
    .set_en(dlv_valid), .set_idx(dlv_vector),
    .clr_en(ack_found), .clr_idx(irr_top),
    .q(irr_q));

  // service set: acknowledge sets, end-of-interrupt clears the top
  lipc_vec_bank #(.N(NVEC), .IW(IDXW)) u_bank_srv (
    .clk(clk), .rst_n(rst_n),
    .set_en(ack_found), .set_idx(irr_top),
    .clr_en(eoi_clr), .clr_idx(isr_top),
    .q(isr_q));

  // trigger set: follows the kind of the latest delivery
  lipc_vec_bank #(.N(NVEC), .IW(IDXW)) u_bank_trg (
    .clk(clk), .rst_n(rst_n),
    .set_en(dlv_valid & dlv_level), .set_idx(dlv_vector),
    .clr_en(dlv_valid & ~dlv_level), .clr_idx(dlv_vector),
    .q(tmr_q));

  always_ff @(posedge clk) begin
    if (!rst_n)            task_prio_q <= '0;
    else if (task_prio_we) task_prio_q <= task_prio_wdata;
  end

  assign core_irq = irr_any & (~isr_any | (irr_top > isr_top));

  assign isr_cls  = isr_any ? isr_top[IDXW-1 -: CLSW] : '0;
  assign tpr_cls  = task_prio_q[IDXW-1 -: CLSW];
  assign cur_prio = (tpr_cls >= isr_cls) ? task_prio_q
                                         : {isr_cls, {LOW_W{1'b0}}};

  logic [WORD_W-1:0] req_w [WORDS];
  logic [WORD_W-1:0] srv_w [WORDS];
  logic [WORD_W-1:0] trg_w [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_words
    assign req_w[w] = irr_q[w*WORD_W +: WORD_W];
    assign srv_w[w] = isr_q[w*WORD_W +: WORD_W];
    assign trg_w[w] = tmr_q[w*WORD_W +: WORD_W];
  end

  always_comb begin
    case (bank_sel_e'(rd_sel))
      SEL_REQ: rd_data = req_w[rd_word];
      SEL_SRV: rd_data = srv_w[rd_word];
      SEL_TRG: rd_data = trg_w[rd_word];
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_checker.sv
`timescale 1ns/1ps
module irq_prio_checker #(
  parameter int NVEC = 256,
  parameter int IDXW = $clog2(NVEC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dlv_valid,
  input logic [IDXW-1:0] dlv_vector,
  input logic            ack_req,
  input logic            ack_found,
  input logic [IDXW-1:0] ack_vector,
  input logic            eoi_strobe,
  input logic            sw_enable,
  input logic            core_irq,
  input logic [IDXW-1:0] task_prio_q,
  input logic [IDXW-1:0] cur_prio,
  input logic [NVEC-1:0] irr_q,
  input logic [NVEC-1:0] isr_q
);
  a_r2_delivery_lands: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> irr_q[$past(dlv_vector)]);

  a_r4_ack_enters_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && ack_found) |=> isr_q[$past(ack_vector)]);

  a_r5_no_vector_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && (!sw_enable || irr_q == '0)) |-> !ack_found);

  a_r6_eoi_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_strobe && !ack_found && isr_q == '0) |=> isr_q == '0);

  a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> irr_q != '0);

  a_r7_idle_service_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q != '0 && isr_q == '0) |-> core_irq);

  a_r8_prio_not_below_task: assert property (@(posedge clk) disable iff (!rst_n)
    cur_prio >= task_prio_q);
endmodule

bind irq_prio_ctrl irq_prio_checker #(.NVEC(NVEC), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .dlv_valid(dlv_valid), .dlv_vector(dlv_vector),
  .ack_req(ack_req), .ack_found(ack_found), .ack_vector(ack_vector),
  .eoi_strobe(eoi_strobe), .sw_enable(sw_enable), .core_irq(core_irq),
  .task_prio_q(task_prio_q), .cur_prio(cur_prio),
  .irr_q(irr_q), .isr_q(isr_q));

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dlv_valid = 1'b0, dlv_level = 1'b0;
  logic [7:0]  dlv_vector = '0;
  logic        dlv_ready;
  logic        ack_req = 1'b0, ack_found;
  logic [7:0]  ack_vector;
  logic        eoi_strobe = 1'b0, sw_enable = 1'b1;
  logic        task_prio_we = 1'b0;
  logic [7:0]  task_prio_wdata = '0, task_prio_q, cur_prio;
  logic        core_irq;
  logic [1:0]  rd_sel = '0;
  logic [2:0]  rd_word = '0;
  logic [31:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  logic [7:0]   m_tpr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_vector(dlv_vector),
    .dlv_level(dlv_level), .ack_req(ack_req), .ack_found(ack_found),
    .ack_vector(ack_vector), .eoi_strobe(eoi_strobe), .sw_enable(sw_enable),
    .task_prio_we(task_prio_we), .task_prio_wdata(task_prio_wdata),
    .task_prio_q(task_prio_q), .cur_prio(cur_prio), .core_irq(core_irq),
    .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_data));

  function automatic int hi(input logic [255:0] v);
    int r = -1;
    for (int i = 0; i < 256; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] exp_prio();
    int c = (m_isr == '0) ? 0 : (hi(m_isr) >> 4);
    if (int'(m_tpr[7:4]) >= c) return m_tpr;
    return 8'(c << 4);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Compare every state-derived output against the model (R9 read-out map).
  task automatic cmp(input string tag);
    logic [255:0] s;
    chk(tag, "core_irq", 32'(core_irq),
        32'(m_irr != '0 && (m_isr == '0 || hi(m_irr) > hi(m_isr))));
    chk(tag, "cur_prio", 32'(cur_prio), 32'(exp_prio()));
    chk(tag, "task_prio_q", 32'(task_prio_q), 32'(m_tpr));
    chk(tag, "dlv_ready", 32'(dlv_ready), 32'd1);
    for (int sel = 0; sel < 3; sel++) begin
      s = (sel == 0) ? m_irr : (sel == 1) ? m_isr : m_tmr;
      for (int w = 0; w < 8; w++) begin
        rd_sel = 2'(sel); rd_word = 3'(w);
        #0.1;
        chk(tag, $sformatf("word sel%0d w%0d", sel, w), rd_data, s[w*32 +: 32]);
      end
    end
    rd_sel = 2'd3; rd_word = 3'd5;
    #0.1;
    chk("R9", "unused select", rd_data, 32'd0);
  endtask

  // One clock cycle of stimulus, starting and ending just after a falling edge.
  task automatic step(input string tag, input bit dv, input logic [7:0] dvec,
                      input bit dlvl, input bit ak, input bit eo);
    bit found;
    int av, ev;
    dlv_valid = dv; dlv_vector = dvec; dlv_level = dlvl;
    ack_req = ak; eoi_strobe = eo;
    #1;
    found = ak && sw_enable && (m_irr != '0);
    av = hi(m_irr);
    if (ak) begin
      chk(tag, "ack_found", 32'(ack_found), 32'(found));
      if (found) chk(tag, "ack_vector", 32'(ack_vector), 32'(av));
    end
    ev = hi(m_isr);
    @(posedge clk);
    #1;
    dlv_valid = 0; ack_req = 0; eoi_strobe = 0;
    if (found) m_irr[av] = 1'b0;
    if (dv) begin m_irr[dvec] = 1'b1; m_tmr[dvec] = dlvl; end
    if (eo && ev >= 0) m_isr[ev] = 1'b0;
    if (found) m_isr[av] = 1'b1;
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic set_tpr(input string tag, input logic [7:0] v);
    task_prio_we = 1; task_prio_wdata = v;
    @(posedge clk); #1 task_prio_we = 0;
    m_tpr = v;
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic t_reset();
    cmp("R1");
    chk("R1", "core_irq low", 32'(core_irq), 32'd0);
    chk("R1", "cur_prio zero", 32'(cur_prio), 32'd0);
  endtask

  task automatic t_deliver();
    step("R2", 1, 8'h45, 1, 0, 0);
    step("R3", 1, 8'h21, 0, 0, 0);
    chk("R7", "raised with empty service", 32'(core_irq), 32'd1);
  endtask

  task automatic t_ack_order();
    step("R4", 0, 8'h00, 0, 1, 0);
    chk("R7", "lower pending does not raise", 32'(core_irq), 32'd0);
  endtask

  task automatic t_prio();
    set_tpr("R8", 8'h30);
    chk("R8", "class wins", 32'(cur_prio), 32'h40);
    set_tpr("R11", 8'h52);
    chk("R11", "task value shows", 32'(cur_prio), 32'h52);
    set_tpr("R8", 8'h47);
    chk("R8", "equal class keeps task", 32'(cur_prio), 32'h47);
  endtask

  task automatic t_nested_eoi();
    step("R7", 1, 8'h90, 1, 0, 0);
    chk("R7", "higher pending raises", 32'(core_irq), 32'd1);
    step("R4", 0, 8'h00, 0, 1, 0);
    step("R6", 0, 8'h00, 0, 0, 1);
    step("R6", 0, 8'h00, 0, 0, 1);
    step("R6", 0, 8'h00, 0, 0, 1);
  endtask

  task automatic t_disabled();
    sw_enable = 0;
    step("R5", 0, 8'h00, 0, 1, 0);
    sw_enable = 1;
  endtask

  task automatic t_empty_ack();
    step("R4", 0, 8'h00, 0, 1, 0);
    step("R5", 0, 8'h00, 0, 1, 0);
  endtask

  task automatic t_same_cycle();
    step("R2", 1, 8'h80, 0, 0, 0);
    step("R10", 1, 8'h10, 0, 1, 1);
    step("R10", 1, 8'h10, 1, 1, 0);
    chk("R10", "re-delivered stays pending", 32'(m_irr[8'h10]), 32'd1);
  endtask

  task automatic t_edges();
    step("R9", 1, 8'hFF, 1, 0, 0);
    step("R9", 1, 8'h00, 1, 0, 0);
    step("R3", 1, 8'hFF, 0, 0, 0);
    step("R4", 0, 8'h00, 0, 1, 0);
    for (int k = 0; k < 4; k++) step("R6", 0, 8'h00, 0, 0, 1);
    for (int k = 0; k < 3; k++) step("R4", 0, 8'h00, 0, 1, 0);
    for (int k = 0; k < 3; k++) step("R6", 0, 8'h00, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_deliver();
    t_ack_order();
    t_prio();
    t_nested_eoi();
    t_disabled();
    t_empty_ack();
    t_same_cycle();
    t_edges();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule